// File: doc/BRIEF.md
# Bank-Gated Depth-Cascaded Memory

This block builds one logical memory of `NUM_BANKS * BANK_BITS` bits (1024 bits with the defaults) out of physical banks of `BANK_BITS` bits each. The banks are stacked by depth. Every bank stores whole output words, and each bank covers a contiguous slice of the logical address space. On every access the bank-select decode turns on only the bank that holds the addressed word. All other banks stay disabled for that cycle, so only one array toggles per access.

The word shape is chosen per access. With the defaults the shapes are 1024x1, 512x2, 256x4, 128x8 and 64x16, and all of them view the same stored bits. A read returns its word one cycle after the request. The output multiplexer is steered by a copy of the bank select that is registered together with the read, so the data always comes from the bank that was addressed, whatever happens on the inputs in the following cycle.

Top module: `bank_gated_mem`

## Requirements
- R1: After reset, and in any cycle whose preceding edge accepted no read, `rdValid` is 0 and `rdData` is all zeros.
- R2: While `req` is 0, every bit of `bankEn` is 0, and a write presented with `req` low changes no stored bit.
- R3: While `req` is 1, exactly one bit of `bankEn` is set. Its index is the top log2(NUM_BANKS) bits of the bit offset, which is `addr` shifted left by log2 of the word width and kept to the address width. For the 1-bit shape this is the top bits of `addr`.
- R4: A read (`req`=1, `wrEn`=0) places its word on `rdData` at the next edge, with `rdValid` 1. The word sits in the low W bits and all higher bits are 0.
- R5: A write (`req`=1, `wrEn`=1) stores the low W bits of `wrData`. Bits of `wrData` above W are ignored.
- R6: Shape codes 0, 1, 2, 3 and 4 select widths 1, 2, 4, 8 and 16, with depth 1024/W. Every shape views the same storage: word A of width W is logical bits A*W up to A*W+W-1, and the lowest of these bits is bit 0 of the word.
- R7: Address bits at and above position log2(1024/W) are ignored.
- R8: The read word comes from the bank that was addressed by the read, even when the next cycle's access addresses a different bank.
- R9: Shape codes 5, 6 and 7 behave exactly like code 4 (16-bit words).
- R10: A write to one bank leaves the contents of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request for this cycle |
| wrEn | input | 1 | 1 = write, 0 = read (valid with req) |
| shape | input | 3 | Word shape code, log2 of the width |
| addr | input | AW (10) | Logical word address in the selected shape |
| wrData | input | MAX_W (16) | Write word, low W bits used |
| rdData | output | MAX_W (16) | Read word, zero-extended |
| rdValid | output | 1 | rdData holds the word of the previous cycle's read |
| bankEn | output | NUM_BANKS (2) | One-hot bank enables of the current access |

## Verification
The registered output path and the bank-enable decode work in the same cycle. The read data from one bank is presented while the enable for the next access is already being driven. The bench issues a read to the upper bank and, in the very next cycle, a write to the lower bank. In that cycle it checks three things: `rdData` carries the upper-bank word, `bankEn` points at the lower bank, and a later read of the lower bank returns the written value. A back-to-back pair of reads across the two banks is judged the same way.

// File: rtl/bgcm_pkg.sv
package bgcm_pkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic rdGo;   // read accepted this cycle
    logic wrGo;   // write accepted this cycle
  } accStrobe_t;

  // Largest shape code with its own width; higher codes fold onto it
  function automatic int clampLog(input logic [2:0] code, input int maxLog);
    if (int'(code) > maxLog) return maxLog;
    return int'(code);
  endfunction

endpackage

// File: rtl/bgcm_bank.sv
module bgcm_bank #(
  parameter int BANK_BITS = 512,
  parameter int MAX_W     = 16,
  localparam int ROWS     = BANK_BITS / MAX_W,
  localparam int RAW      = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [RAW-1:0]   row,
  input  logic [MAX_W-1:0] wMask,
  input  logic [MAX_W-1:0] wData,
  output logic [MAX_W-1:0] rData
);

  logic [MAX_W-1:0] mem [ROWS];

  // Bit-masked write; a disabled bank neither writes nor reads
  always_ff @(posedge clk) begin
    if (wrEn) begin
      for (int i = 0; i < MAX_W; i++) begin
        if (wMask[i]) mem[row][i] <= wData[i];
      end
    end else if (rdEn) begin
      rData <= mem[row];
    end
  end

endmodule

// File: rtl/bgcm_ctrl.sv
module bgcm_ctrl
  import bgcm_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_BITS = 512,
  parameter int MAX_W     = 16,
  localparam int BSW      = $clog2(NUM_BANKS),
  localparam int BAW      = $clog2(BANK_BITS),
  localparam int AW       = BAW + BSW,
  localparam int CW       = $clog2(MAX_W),
  localparam int LW       = $clog2(CW + 1),
  localparam int RAW      = BAW - CW
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 req,
  input  logic                 wrEn,
  input  logic [2:0]           shape,
  input  logic [AW-1:0]        addr,
  input  logic [MAX_W-1:0]     wrData,
  output accStrobe_t           strobe,
  output logic [NUM_BANKS-1:0] bankEn,
  output logic [RAW-1:0]       row,
  output logic [MAX_W-1:0]     wMask,
  output logic [MAX_W-1:0]     wData,
  output logic [BSW-1:0]       rdBankQ,
  output logic [CW-1:0]        rdColQ,
  output logic [LW-1:0]        rdLogQ,
  output logic                 rdValidQ
);

  logic [LW-1:0]    wLog;
  logic [AW-1:0]    bitOff;
  logic [BSW-1:0]   bankSel;
  logic [CW-1:0]    col;
  logic [MAX_W-1:0] laneMask;

  // Shape decode and address to bit-offset mapping
  always_comb begin
    wLog    = LW'(clampLog(shape, CW));
    bitOff  = addr << wLog;              // top wLog address bits fall off
    bankSel = bitOff[AW-1 -: BSW];
    row     = bitOff[BAW-1:CW];
    col     = bitOff[CW-1:0];
    for (int i = 0; i < MAX_W; i++) begin
      laneMask[i] = (i < (1 << wLog));
    end
    wMask = laneMask << col;
    wData = (wrData & laneMask) << col;
  end

  // Access strobes
  always_comb begin
    strobe.rdGo = req & ~wrEn;
    strobe.wrGo = req & wrEn;
  end

  // One-hot bank enables, all low when idle
  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
      assign bankEn[b] = req && (bankSel == BSW'(b));
    end
  endgenerate

  // Mux select and lane position registered alongside the read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      rdBankQ  <= '0;
      rdColQ   <= '0;
      rdLogQ   <= '0;
    end else begin
      rdValidQ <= strobe.rdGo;
      if (strobe.rdGo) begin
        rdBankQ <= bankSel;
        rdColQ  <= col;
        rdLogQ  <= wLog;
      end
    end
  end

endmodule

// File: rtl/bgcm_datapath.sv
module bgcm_datapath
  import bgcm_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_BITS = 512,
  parameter int MAX_W     = 16,
  localparam int BSW      = $clog2(NUM_BANKS),
  localparam int BAW      = $clog2(BANK_BITS),
  localparam int CW       = $clog2(MAX_W),
  localparam int LW       = $clog2(CW + 1),
  localparam int RAW      = BAW - CW
) (
  input  logic                 clk,
  input  accStrobe_t           strobe,
  input  logic [NUM_BANKS-1:0] bankEn,
  input  logic [RAW-1:0]       row,
  input  logic [MAX_W-1:0]     wMask,
  input  logic [MAX_W-1:0]     wData,
  input  logic [BSW-1:0]       rdBankQ,
  input  logic [CW-1:0]        rdColQ,
  input  logic [LW-1:0]        rdLogQ,
  input  logic                 rdValidQ,
  output logic [MAX_W-1:0]     rdData
);

  logic [MAX_W-1:0] bankRd [NUM_BANKS];
  logic [MAX_W-1:0] selWord;
  logic [MAX_W-1:0] shifted;
  logic [MAX_W-1:0] outMask;

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      bgcm_bank #(
        .BANK_BITS(BANK_BITS),
        .MAX_W    (MAX_W)
      ) u_bank (
        .clk  (clk),
        .rdEn (bankEn[g] & strobe.rdGo),
        .wrEn (bankEn[g] & strobe.wrGo),
        .row  (row),
        .wMask(wMask),
        .wData(wData),
        .rData(bankRd[g])
      );
    end
  endgenerate

  // Output mux by registered bank, then lane extraction
  always_comb begin
    selWord = bankRd[rdBankQ];
    shifted = selWord >> rdColQ;
    for (int i = 0; i < MAX_W; i++) begin
      outMask[i] = (i < (1 << rdLogQ));
    end
    rdData = rdValidQ ? (shifted & outMask) : '0;
  end

endmodule

// File: rtl/bank_gated_mem.sv
module bank_gated_mem
  import bgcm_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_BITS = 512,
  parameter int MAX_W     = 16,
  localparam int BSW      = $clog2(NUM_BANKS),
  localparam int BAW      = $clog2(BANK_BITS),
  localparam int AW       = BAW + BSW,
  localparam int CW       = $clog2(MAX_W),
  localparam int LW       = $clog2(CW + 1),
  localparam int RAW      = BAW - CW
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 req,
  input  logic                 wrEn,
  input  logic [2:0]           shape,
  input  logic [AW-1:0]        addr,
  input  logic [MAX_W-1:0]     wrData,
  output logic [MAX_W-1:0]     rdData,
  output logic                 rdValid,
  output logic [NUM_BANKS-1:0] bankEn
);

  accStrobe_t       strobe;
  logic [RAW-1:0]   row;
  logic [MAX_W-1:0] wMask;
  logic [MAX_W-1:0] wData;
  logic [BSW-1:0]   rdBankQ;
  logic [CW-1:0]    rdColQ;
  logic [LW-1:0]    rdLogQ;

  bgcm_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_BITS(BANK_BITS),
    .MAX_W    (MAX_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .req     (req),
    .wrEn    (wrEn),
    .shape   (shape),
    .addr    (addr),
    .wrData  (wrData),
    .strobe  (strobe),
    .bankEn  (bankEn),
    .row     (row),
    .wMask   (wMask),
    .wData   (wData),
    .rdBankQ (rdBankQ),
    .rdColQ  (rdColQ),
    .rdLogQ  (rdLogQ),
    .rdValidQ(rdValid)
  );

  bgcm_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_BITS(BANK_BITS),
    .MAX_W    (MAX_W)
  ) u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .bankEn  (bankEn),
    .row     (row),
    .wMask   (wMask),
    .wData   (wData),
    .rdBankQ (rdBankQ),
    .rdColQ  (rdColQ),
    .rdLogQ  (rdLogQ),
    .rdValidQ(rdValid),
    .rdData  (rdData)
  );

endmodule

// File: rtl/bgcm_checker.sv
module bgcm_checker #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_BITS = 512,
  parameter int MAX_W     = 16,
  localparam int BSW      = $clog2(NUM_BANKS),
  localparam int AW       = $clog2(BANK_BITS) + BSW
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 req,
  input logic                 wrEn,
  input logic [2:0]           shape,
  input logic [AW-1:0]        addr,
  input logic [MAX_W-1:0]     rdData,
  input logic                 rdValid,
  input logic [NUM_BANKS-1:0] bankEn
);

  assert_onehot_en_R3: assert property (@(posedge clk) disable iff (!rstN)
    req |-> $countones(bankEn) == 1);

  assert_x1_bank_R3: assert property (@(posedge clk) disable iff (!rstN)
    (req && shape == 3'd0) |-> bankEn == (NUM_BANKS'(1) << addr[AW-1 -: BSW]));

  assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !req |-> bankEn == '0);

  assert_rd_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    (req && !wrEn) |=> rdValid);

  assert_no_stray_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(req && !wrEn) |=> !rdValid);

  assert_quiet_data_R1: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> rdData == '0);

  assert_lane_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (req && !wrEn && shape == 3'd0) |=> rdData[MAX_W-1:1] == '0);

endmodule

bind bank_gated_mem bgcm_checker #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_BITS(BANK_BITS),
  .MAX_W    (MAX_W)
) u_check (
  .clk    (clk),
  .rstN   (rstN),
  .req    (req),
  .wrEn   (wrEn),
  .shape  (shape),
  .addr   (addr),
  .rdData (rdData),
  .rdValid(rdValid),
  .bankEn (bankEn)
);

// File: tb/tb_bank_gated_mem.sv
module tb_bank_gated_mem;

  localparam int NB  = 2;
  localparam int BB  = 512;
  localparam int MW  = 16;
  localparam int AW  = 10;
  localparam int TOT = NB * BB;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rstN, req, wrEn, rdValid;
  logic [2:0]    shape;
  logic [AW-1:0] addr;
  logic [MW-1:0] wrData, rdData;
  logic [NB-1:0] bankEn;

  logic [TOT-1:0] refMem;
  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  bank_gated_mem dut (
    .clk(clk), .rstN(rstN), .req(req), .wrEn(wrEn), .shape(shape),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .bankEn(bankEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int lg(input logic [2:0] s);
    return (int'(s) > 4) ? 4 : int'(s);
  endfunction

  function automatic int baseOf(input logic [2:0] s, input logic [AW-1:0] a);
    return (int'(a) << lg(s)) % TOT;
  endfunction

  function automatic logic [MW-1:0] pat(input int i);
    return MW'(i * 40503) ^ 16'h5A5A;
  endfunction

  function automatic logic [MW-1:0] expWord(input logic [2:0] s, input logic [AW-1:0] a);
    logic [MW-1:0] e = '0;
    int b = baseOf(s, a);
    for (int j = 0; j < (1 << lg(s)); j++) e[j] = refMem[b + j];
    return e;
  endfunction

  task automatic wr(input logic [2:0] s, input logic [AW-1:0] a, input logic [MW-1:0] d, input string tag);
    int b = baseOf(s, a);
    @(negedge clk);
    req = 1'b1; wrEn = 1'b1; shape = s; addr = a; wrData = d;
    #1 chk({tag, " R3 bankEn"}, 32'(bankEn), 32'(1 << (b / BB)));
    @(negedge clk);
    req = 1'b0; wrEn = 1'b0;
    for (int j = 0; j < (1 << lg(s)); j++) refMem[b + j] = d[j];
  endtask

  task automatic rd(input logic [2:0] s, input logic [AW-1:0] a, input string tag);
    logic [MW-1:0] e = expWord(s, a);
    int b = baseOf(s, a);
    @(negedge clk);
    req = 1'b1; wrEn = 1'b0; shape = s; addr = a;
    #1 chk({tag, " R3 bankEn"}, 32'(bankEn), 32'(1 << (b / BB)));
    @(negedge clk);
    req = 1'b0;
    #1 chk({tag, " R4 rdValid"}, 32'(rdValid), 32'd1);
    chk({tag, " R4 rdData"}, 32'(rdData), 32'(e));
  endtask

  task automatic testReset();
    rstN = 1'b0; req = 1'b0; wrEn = 1'b0; shape = '0; addr = '0; wrData = '0;
    refMem = '0;
    repeat (3) @(negedge clk);
    chk("R1 rdValid in reset", 32'(rdValid), 32'd0);
    chk("R1 rdData in reset", 32'(rdData), 32'd0);
    chk("R2 bankEn in reset", 32'(bankEn), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rdValid after reset", 32'(rdValid), 32'd0);
    chk("R2 bankEn idle", 32'(bankEn), 32'd0);
  endtask

  task automatic testFill16();
    for (int i = 0; i < 64; i++) wr(3'd4, AW'(i), pat(i), "R5 fill x16");
    for (int i = 0; i < 64; i++) rd(3'd4, AW'(i), "R6 readback x16");
  endtask

  task automatic testShapes();
    rd(3'd0, 10'd0,   "R6 x1");
    rd(3'd0, 10'd511, "R6 x1 bank0 top");
    rd(3'd0, 10'd512, "R6 x1 bank1 first");
    rd(3'd0, 10'd1023,"R6 x1 last");
    rd(3'd1, 10'd255, "R6 x2");
    rd(3'd1, 10'd256, "R6 x2 bank1");
    rd(3'd2, 10'd127, "R6 x4");
    rd(3'd2, 10'd200, "R6 x4 bank1");
    rd(3'd3, 10'd63,  "R6 x8");
    rd(3'd3, 10'd64,  "R6 x8 bank1");
    wr(3'd2, 10'd3, 16'hFFF5, "R5 x4 upper bits");
    rd(3'd4, 10'd0, "R5 x4 upper bits ignored");
    wr(3'd0, 10'd600, 16'hFFFE, "R5 x1 write zero");
    rd(3'd3, 10'd75, "R6 x1 seen through x8");
  endtask

  task automatic testAddrIgnore();
    wr(3'd4, 10'h3C5, 16'hC0DE, "R7 x16 high addr");
    rd(3'd4, 10'h005, "R7 x16 plain addr");
    rd(3'd3, 10'h30A, "R7 x8 high addr");
    rd(3'd1, 10'h3FF, "R7 x2 high addr");
  endtask

  task automatic testIdle();
    @(negedge clk);
    req = 1'b0; wrEn = 1'b1; shape = 3'd4; addr = '0; wrData = ~pat(0);
    #1 chk("R2 bankEn idle write", 32'(bankEn), 32'd0);
    @(negedge clk);
    wrEn = 1'b0;
    #1 chk("R1 no read no valid", 32'(rdValid), 32'd0);
    rd(3'd4, 10'd0, "R2 idle write had no effect");
  endtask

  task automatic testBackToBack();
    logic [MW-1:0] eHi, eLo;
    eHi = expWord(3'd4, 10'd40);
    eLo = expWord(3'd4, 10'd7);
    @(negedge clk);
    req = 1'b1; wrEn = 1'b0; shape = 3'd4; addr = 10'd40;
    #1 chk("R3 read upper bank", 32'(bankEn), 32'd2);
    @(negedge clk);
    wrEn = 1'b1; addr = 10'd3; wrData = 16'hBEEF;
    #1 chk("R8 data from upper bank", 32'(rdData), 32'(eHi));
    chk("R8 valid", 32'(rdValid), 32'd1);
    chk("R3 write lower bank", 32'(bankEn), 32'd1);
    @(negedge clk);
    req = 1'b0; wrEn = 1'b0;
    for (int j = 0; j < 16; j++) refMem[48 + j] = 1'(16'hBEEF >> j);
    #1 chk("R1 valid drops after write", 32'(rdValid), 32'd0);
    chk("R1 data quiet after write", 32'(rdData), 32'd0);
    rd(3'd4, 10'd3, "R8 lower bank write landed");
    @(negedge clk);
    req = 1'b1; wrEn = 1'b0; addr = 10'd7;
    @(negedge clk);
    addr = 10'd40;
    #1 chk("R8 back-to-back lower", 32'(rdData), 32'(eLo));
    @(negedge clk);
    req = 1'b0;
    #1 chk("R8 back-to-back upper", 32'(rdData), 32'(eHi));
  endtask

  task automatic testReserved();
    wr(3'd7, 10'd20, 16'h1234, "R9 code7 write");
    rd(3'd4, 10'd20, "R9 code7 as x16");
    rd(3'd5, 10'd20, "R9 code5 read");
    rd(3'd6, 10'd50, "R9 code6 read");
  endtask

  task automatic testIsolation();
    logic [MW-1:0] saved [32];
    for (int i = 0; i < 32; i++) saved[i] = expWord(3'd4, AW'(32 + i));
    for (int i = 0; i < 32; i++) wr(3'd4, AW'(i), ~pat(i + 7), "R10 rewrite bank0");
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      req = 1'b1; wrEn = 1'b0; shape = 3'd4; addr = AW'(32 + i);
      @(negedge clk);
      req = 1'b0;
      #1 chk("R10 bank1 untouched", 32'(rdData), 32'(saved[i]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    testReset();
    testFill16();
    testShapes();
    testAddrIgnore();
    testIdle();
    testBackToBack();
    testReserved();
    testIsolation();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule